// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits next to a small 8-bit processor core and makes the interrupt decision at each instruction boundary. When the core reports that an instruction has completed, the block looks at the software-interrupt decode, a synchronized external request line and three timer status flags, each gated by its own enable bit. Hardware sources are also gated by the core's global mask bit. If a source wins, the block raises a one-cycle take strobe and asks the core to set the mask bit. It then latches the address of the high byte of the winning two-byte vector.

The vector table holds one pair of bytes per source at the top of a 16-address window. Reset uses the highest pair, followed by software interrupt, external request and timer. The three timer flags share the timer pair. When several sources are pending, the source with the higher vector address wins. The latched address stays stable through the core's two-cycle vector fetch, and no new decision is taken during that fetch. Reset is asynchronous, overrides everything else and forces the reset vector.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rstReq` is high, and asynchronously from the moment it rises, `vecAddr` is 0x3FFE, `takeIrq` is 0 and `setMask` is 1. After `rstReq` falls, `takeIrq` stays 0 for the next two cycles so that the core can fetch the reset vector.
- R2: `takeIrq` can be 1 only in a cycle where `instrDone` is 1. With `instrDone` at 0, no source is taken.
- R3: A hardware source (external request or timer) is taken only when `maskBit` is 0. A timer flag whose enable bit is 0 never causes a take.
- R4: When `instrDone` and `swiExec` are both 1 and no vector fetch is in progress, the interrupt is taken whatever the value of `maskBit`, and the vector is 0x3FFC.
- R5: `setMask` is 1 in every cycle in which `takeIrq` is 1.
- R6: The timer request is the OR over bits 0 (input capture), 1 (output compare) and 2 (overflow) of `tmrFlags[i] & tmrEn[i]`. Any of these flags selects vector 0x3FF8.
- R7: When several sources qualify in the same cycle, the order is software interrupt (0x3FFC), then external (0x3FFA), then timer (0x3FF8).
- R8: `vecAddr` takes the new address at the clock edge that ends the take cycle. The address then holds, and `takeIrq` stays 0, for the following two cycles, even if requests are present.
- R9: `extIrq` passes through a two-flop synchronizer. A level on `extIrq` that is present at two consecutive rising edges becomes visible to the decision in the cycle after the second of those edges.
- R10: With no qualifying request, `takeIrq` stays 0 and `vecAddr` keeps its value. `vecAddr` is only ever 0x3FFE, 0x3FFC, 0x3FFA or 0x3FF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstReq | input | 1 | Reset request, active high, asynchronous assert |
| instrDone | input | 1 | Current instruction completes this cycle |
| swiExec | input | 1 | Software-interrupt instruction decoded and completing |
| extIrq | input | 1 | External interrupt request, asynchronous, active high |
| tmrFlags | input | 3 | Timer flags: bit0 capture, bit1 compare, bit2 overflow |
| tmrEn | input | 3 | Per-flag enable bits, same bit order as tmrFlags |
| maskBit | input | 1 | Global hardware interrupt mask from the core |
| takeIrq | output | 1 | Take-interrupt strobe |
| setMask | output | 1 | Request to the core to set the mask bit |
| vecAddr | output | 16 | Address of the high byte of the selected vector |

## Verification
Directed patterns exercise each source on its own: a software interrupt with the mask set, each timer flag with and without its enable, and an external pulse timed against the synchronizer. These patterns separate mask gating from enable gating and expose an off-by-one in the synchronizer delay. Combined patterns raise every source at once and then drop them one at a time, which shows whether the priority order follows the vector address. Requests kept active through the two fetch cycles, and a reset asserted between clock edges, test the hold window and the asynchronous override. Random cycles with mixed boundary, mask and flag settings are checked against a reference model in the bench.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    SRC_RESET = 2'd0,
    SRC_SWI   = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_TMR   = 2'd3
  } vecSrc_e;

  typedef struct packed {
    logic    load;
    vecSrc_e src;
  } ctrlStrobe_t;
endpackage

// File: rtl/ivc_control.sv
module ivc_control
  import ivc_pkg::*;
#(
  parameter int NUM_TMR      = 3,
  parameter int FETCH_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstReq,
  input  logic               instrDone,
  input  logic               swiExec,
  input  logic               extSynced,
  input  logic [NUM_TMR-1:0] tmrFlags,
  input  logic [NUM_TMR-1:0] tmrEn,
  input  logic               maskBit,
  output ctrlStrobe_t        strobe,
  output logic               takeIrq
);
  localparam int CNT_W = $clog2(FETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(FETCH_CYCLES);

  logic [NUM_TMR-1:0] tmrHit;
  logic               tmrReq;
  logic               extReq;
  logic               hwReq;
  logic               busy;
  logic [CNT_W-1:0]   holdCnt;

  // each timer flag is qualified by its own enable
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmrGate
    assign tmrHit[g] = tmrFlags[g] & tmrEn[g];
  end

  assign tmrReq  = |tmrHit;
  assign extReq  = extSynced & ~maskBit;
  assign hwReq   = extReq | (tmrReq & ~maskBit);
  assign busy    = (holdCnt != '0);
  assign takeIrq = instrDone & ~busy & (swiExec | hwReq);

  // winner follows vector address order
  always_comb begin
    strobe.load = takeIrq;
    if (swiExec)     strobe.src = SRC_SWI;
    else if (extReq) strobe.src = SRC_EXT;
    else             strobe.src = SRC_TMR;
  end

  // fetch hold window; reset leaves time to fetch the reset vector
  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq)            holdCnt <= HOLD_LOAD;
    else if (takeIrq)      holdCnt <= HOLD_LOAD;
    else if (holdCnt != 0) holdCnt <= holdCnt - 1'b1;
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP     = 16'h3FFE,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstReq,
  input  logic              extIrq,
  input  ctrlStrobe_t       strobe,
  output logic              extSynced,
  output logic [ADDR_W-1:0] vecAddr
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [ADDR_W-1:0]      nextAddr;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or posedge rstReq) begin
        if (rstReq) syncQ[0] <= 1'b0;
        else        syncQ[0] <= extIrq;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge rstReq) begin
        if (rstReq) syncQ[s] <= 1'b0;
        else        syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign extSynced = syncQ[SYNC_STAGES-1];

  // each source rank steps two bytes down from the top pair
  assign nextAddr = VEC_TOP - ADDR_W'({strobe.src, 1'b0});

  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq)          vecAddr <= VEC_TOP;
    else if (strobe.load) vecAddr <= nextAddr;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP      = 16'h3FFE,
  parameter int                NUM_TMR      = 3,
  parameter int                FETCH_CYCLES = 2,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstReq,
  input  logic               instrDone,
  input  logic               swiExec,
  input  logic               extIrq,
  input  logic [NUM_TMR-1:0] tmrFlags,
  input  logic [NUM_TMR-1:0] tmrEn,
  input  logic               maskBit,
  output logic               takeIrq,
  output logic               setMask,
  output logic [ADDR_W-1:0]  vecAddr
);
  ctrlStrobe_t strobe;
  logic        extSynced;

  ivc_control #(
    .NUM_TMR     (NUM_TMR),
    .FETCH_CYCLES(FETCH_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstReq   (rstReq),
    .instrDone(instrDone),
    .swiExec  (swiExec),
    .extSynced(extSynced),
    .tmrFlags (tmrFlags),
    .tmrEn    (tmrEn),
    .maskBit  (maskBit),
    .strobe   (strobe),
    .takeIrq  (takeIrq)
  );

  ivc_datapath #(
    .ADDR_W     (ADDR_W),
    .VEC_TOP    (VEC_TOP),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstReq   (rstReq),
    .extIrq   (extIrq),
    .strobe   (strobe),
    .extSynced(extSynced),
    .vecAddr  (vecAddr)
  );

  assign setMask = takeIrq | rstReq;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstReq,
  input logic              instrDone,
  input logic              swiExec,
  input logic              maskBit,
  input logic              takeIrq,
  input logic              setMask,
  input logic [ADDR_W-1:0] vecAddr
);
  p_reset_vec_r1: assert property (@(posedge clk)
    rstReq |-> (vecAddr == ADDR_W'(16'h3FFE) && !takeIrq && setMask));

  p_boundary_r2: assert property (@(posedge clk) disable iff (rstReq)
    takeIrq |-> instrDone);

  p_hw_masked_r3: assert property (@(posedge clk) disable iff (rstReq)
    (takeIrq && !swiExec) |-> !maskBit);

  p_mask_req_r5: assert property (@(posedge clk) disable iff (rstReq)
    takeIrq |-> setMask);

  p_swi_first_r7: assert property (@(posedge clk) disable iff (rstReq)
    (takeIrq && swiExec) |=> (vecAddr == ADDR_W'(16'h3FFC)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rstReq)
    takeIrq |=> (!takeIrq ##1 (!takeIrq && $stable(vecAddr))));

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rstReq)
    !$past(takeIrq) |-> $stable(vecAddr));

  p_legal_addr_r10: assert property (@(posedge clk)
    (vecAddr == ADDR_W'(16'h3FFE) || vecAddr == ADDR_W'(16'h3FFC) ||
     vecAddr == ADDR_W'(16'h3FFA) || vecAddr == ADDR_W'(16'h3FF8)));
endmodule

bind irq_vector_ctrl ivc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstReq   (rstReq),
  .instrDone(instrDone),
  .swiExec  (swiExec),
  .maskBit  (maskBit),
  .takeIrq  (takeIrq),
  .setMask  (setMask),
  .vecAddr  (vecAddr)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rstReq;
  logic        instrDone, swiExec, extIrq, maskBit;
  logic [2:0]  tmrFlags, tmrEn;
  logic        takeIrq, setMask;
  logic [15:0] vecAddr;

  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 0;

  // reference model state
  int          mBusy;
  logic [1:0]  mPipe;
  logic [15:0] mAddr;

  always #2 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rstReq(rstReq), .instrDone(instrDone), .swiExec(swiExec),
    .extIrq(extIrq), .tmrFlags(tmrFlags), .tmrEn(tmrEn), .maskBit(maskBit),
    .takeIrq(takeIrq), .setMask(setMask), .vecAddr(vecAddr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expTake(input logic id, sw, mk, input logic [2:0] fl, en);
    return id && (mBusy == 0) && (sw || (!mk && (mPipe[1] || |(fl & en))));
  endfunction

  function automatic logic [15:0] expVec(input logic sw, mk);
    if (sw)                 return 16'h3FFC;
    else if (mPipe[1] && !mk) return 16'h3FFA;
    else                    return 16'h3FF8;
  endfunction

  // called at a falling edge; drives, checks, steps one clock
  task automatic cyc(input logic id, sw, ex, mk, input logic [2:0] fl, en, input string tag);
    bit t;
    instrDone = id; swiExec = sw; extIrq = ex; maskBit = mk;
    tmrFlags = fl; tmrEn = en;
    #1;
    t = expTake(id, sw, mk, fl, en);
    check(takeIrq == t, {tag, " take"}, int'(takeIrq), int'(t));
    if (t) check(setMask == 1'b1, "R5 setMask", int'(setMask), 1);
    @(posedge clk);
    if (t) begin
      mAddr = expVec(sw, mk);
      mBusy = 2;
    end else if (mBusy > 0) mBusy--;
    mPipe = {mPipe[0], ex};
    @(negedge clk);
    check(vecAddr == mAddr, {tag, " vecAddr"}, int'(vecAddr), int'(mAddr));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 3'b000, 3'b000, "R10");
  endtask

  task automatic doReset();
    rstReq = 1'b1;
    #1;
    check(vecAddr == 16'h3FFE, "R1 async vecAddr", int'(vecAddr), 'h3FFE);
    check(takeIrq == 1'b0, "R1 take", int'(takeIrq), 0);
    check(setMask == 1'b1, "R1 setMask", int'(setMask), 1);
    @(negedge clk);
    @(negedge clk);
    check(vecAddr == 16'h3FFE, "R1 vecAddr held", int'(vecAddr), 'h3FFE);
    mBusy = 2; mPipe = 2'b00; mAddr = 16'h3FFE;
    rstReq = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    instrDone = 0; swiExec = 0; extIrq = 0; maskBit = 1;
    tmrFlags = 0; tmrEn = 0; rstReq = 1;
    @(negedge clk);
    doReset();
    // R1: requests right after reset are held off for two cycles
    cyc(1, 1, 0, 0, 3'b000, 3'b000, "R1 post-reset hold");
    cyc(1, 1, 0, 0, 3'b000, 3'b000, "R1 post-reset hold");
    idle(1);
    // R10: boundary, unmasked, nothing pending
    cyc(1, 0, 0, 0, 3'b000, 3'b111, "R10");
    // R2: software interrupt without a boundary
    cyc(0, 1, 0, 0, 3'b111, 3'b111, "R2");
    // R4: software interrupt with the mask set
    cyc(1, 1, 0, 1, 3'b000, 3'b000, "R4");
    // R8: requests during the fetch window
    cyc(1, 1, 0, 0, 3'b111, 3'b111, "R8");
    cyc(1, 1, 0, 0, 3'b111, 3'b111, "R8");
    idle(1);
    // R6: each timer flag alone
    for (int b = 0; b < 3; b++) begin
      cyc(1, 0, 0, 0, 3'(1 << b), 3'(1 << b), "R6");
      idle(2);
    end
    // R3: flag without its enable, and enabled flag under mask
    cyc(1, 0, 0, 0, 3'b101, 3'b010, "R3");
    cyc(1, 0, 0, 1, 3'b111, 3'b111, "R3");
    // R9: external pulse through the synchronizer
    cyc(1, 0, 1, 0, 3'b000, 3'b000, "R9");
    cyc(1, 0, 1, 0, 3'b000, 3'b000, "R9");
    cyc(1, 0, 1, 0, 3'b000, 3'b000, "R9");
    idle(3);
    // R3: synchronized external level while masked
    cyc(0, 0, 1, 1, 3'b000, 3'b000, "R3");
    cyc(0, 0, 1, 1, 3'b000, 3'b000, "R3");
    cyc(1, 0, 1, 1, 3'b000, 3'b000, "R3");
    // R7: everything at once, then drop the top one
    cyc(1, 1, 1, 0, 3'b111, 3'b111, "R7");
    cyc(0, 0, 1, 0, 3'b111, 3'b111, "R7");
    cyc(0, 0, 1, 0, 3'b111, 3'b111, "R7");
    cyc(1, 0, 1, 0, 3'b111, 3'b111, "R7");
    idle(3);
    // R1: asynchronous reset between edges
    @(negedge clk);
    #0.5;
    doReset();
    cyc(0, 0, 0, 0, 3'b000, 3'b000, "R1");
    cyc(0, 0, 0, 0, 3'b000, 3'b000, "R1");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 2) == 0, ($urandom % 7) == 0, ($urandom % 3) == 0,
          ($urandom % 2) == 0, 3'($urandom), 3'($urandom), "R7 random");
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule